// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI bus master behind a small 32-bit register port. Software programs the serial clock divider, word length, clock polarity, clock phase and bit order while the block sits in configuration mode. It then switches to active mode and writes words into a data port. Each word written is queued in a short transmit FIFO. The shifter drives it out on the serial clock and data output, and it collects the word arriving on the serial data input into a receive FIFO.

Software reads received words back through the same data port. It can either poll a status register or wait for a level interrupt. That interrupt asserts once the receive FIFO holds more than a programmed number of words. Chip select is handled outside the block.

Register map (byte offsets): master control 0x00, control A 0x04, control B 0x08, status 0x14, data port 0x18. Reads return data on the cycle after `bus_rd`.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset the master control register reads 0x40 (configuration mode), control A reads 0, control B reads 0x0108 (divider 1, 8-bit words), status reads 0x0004, and `irq` and `sck` are 0.
- R2: Master control bits 7:6 select the mode: 01 is configuration and 10 is active. Writes of 00 or 11 leave the mode unchanged. Bit 1 is a stop request, and bit 0 always reads 0.
- R3: Control A bit 0 (clock polarity), bit 1 (clock phase) and bit 2 (1 = MSB first) and all of control B change only on writes made in configuration mode. Control A bits 13:12 (receive threshold t) and bit 9 (interrupt enable) take a write in either mode.
- R4: Control B bits 15:8 hold the divider n, and a write of 0 is stored as 1. One serial clock period lasts n+1 system clock cycles.
- R5: Control B bits 4:0 written as 16 select 16-bit words, and any other value selects 8-bit words; the field reads back as 16 or 8. An 8-bit word uses data bits 7:0, and other data bits are ignored.
- R6: `sck` rests at the polarity level when idle. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge. The bits go out MSB first or LSB first as control A bit 2 selects.
- R7: The transmit FIFO holds 4 words. A data-port write to a full FIFO is dropped. Status bits 13:11 give its occupancy.
- R8: In active mode with the stop bit clear, words are shifted out while the transmit FIFO is non-empty. Each finished word pushes its received word into the receive FIFO. With the stop bit set, or in configuration mode, no new word starts.
- R9: A data-port read pops the receive FIFO and returns 0 when the FIFO is empty. Status bits 10:8 give the receive occupancy.
- R10: Status bit 14 is 1 while the receive FIFO holds t+1 or more words. `irq` equals bit 14 AND control A bit 9, one cycle later.
- R11: Status bit 7 sets when a word finishes while the receive FIFO is full. That word is dropped, and a read in the same cycle does not make room for it.
- R12: A master-control write with bits 7:6 = 01 and bit 0 = 1 empties both FIFOs and clears status bit 7.
- R13: Status bit 2 is 1 exactly when the shifter is idle and the transmit FIFO is empty.
- R14: A switch to configuration mode during a word lets that word finish, then holds the remaining words in the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data-port read pops the receive FIFO |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Receive-threshold interrupt (level) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The serial path is exercised with six transfers covering all four polarity/phase pairs, both bit orders, both word lengths and several dividers, including a divider written as 0. A monitor rebuilds each word from the clock edges and measures the clock period. The bench checks these against the data written, so a swapped edge or bit order shows up as a wrong word and a wrong divide shows up as a wrong period. The serial output loops back to the input, plain for some transfers and inverted for others. The inverted loopback separates a received word that was actually sampled from one merely copied out of the transmit path. Directed sequences then fill the transmit FIFO past capacity, drive the receive FIFO to its threshold and into overrun, clear the buffers, hold words back with the stop bit and leave active mode mid-word. Each of these shows up as a distinct value in the occupancy and flag fields.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int WORD_MAX = 16;
  localparam int DIV_W    = 8;

  typedef enum logic [1:0] {
    MODE_CFG = 2'b01,
    MODE_ACT = 2'b10
  } op_mode_e;

  localparam int OFS_MCTL = 'h00;
  localparam int OFS_CTLA = 'h04;
  localparam int OFS_CTLB = 'h08;
  localparam int OFS_STAT = 'h14;
  localparam int OFS_DATA = 'h18;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clear,
  input  logic                           push,
  input  logic [WIDTH-1:0]               wdata,
  input  logic                           pop,
  output logic [WIDTH-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && !empty && !clear;
  assign count   = cnt_q;
  assign rdata   = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= nxt(wp_q);
      if (pop_ok)  rp_q <= nxt(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clear) |=> (count == CW'(DEPTH)));

  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (rst)
    clear |=> empty);
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter
  import spim_pkg::*;
#(
  parameter int WMAX = WORD_MAX,
  parameter int DW   = DIV_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WMAX-1:0] tx_word,
  input  logic            len16,
  input  logic            msb_first,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [DW-1:0]   div,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [WMAX-1:0] rx_word,
  output logic            sck,
  output logic            mosi
);
  localparam int HALF  = WMAX / 2;
  localparam int BIT_W = $clog2(WMAX);

  logic            busy_q, done_q, sck_q, mosi_q;
  logic [DW-1:0]   cyc_q, div_l;
  logic [BIT_W-1:0] bit_q;
  logic [WMAX-1:0] tx_sh, rx_sh;
  logic            w16_l, msb_l, pol_l, pha_l;
  logic [DW:0]     plus1;
  logic [DW-1:0]   lead_at;
  logic            last_bit;

  assign plus1    = {1'b0, div_l} + 1'b1;
  assign lead_at  = DW'((plus1 >> 1) - 1'b1);
  assign last_bit = (bit_q == (w16_l ? BIT_W'(WMAX - 1) : BIT_W'(HALF - 1)));

  function automatic logic pick(input logic [WMAX-1:0] s, input logic m, input logic w);
    if (!m)     return s[0];
    else if (w) return s[WMAX-1];
    else        return s[HALF-1];
  endfunction

  function automatic logic [WMAX-1:0] adv(input logic [WMAX-1:0] s, input logic m);
    return m ? (s << 1) : (s >> 1);
  endfunction

  function automatic logic [WMAX-1:0] samp(input logic [WMAX-1:0] s, input logic b,
                                           input logic m);
    return m ? {s[WMAX-2:0], b} : {b, s[WMAX-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      cyc_q  <= '0;
      bit_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      div_l  <= DW'(1);
      w16_l  <= 1'b0;
      msb_l  <= 1'b1;
      pol_l  <= 1'b0;
      pha_l  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sck_q <= cpol;
        if (start) begin
          busy_q <= 1'b1;
          cyc_q  <= '0;
          bit_q  <= '0;
          tx_sh  <= tx_word;
          rx_sh  <= '0;
          div_l  <= div;
          w16_l  <= len16;
          msb_l  <= msb_first;
          pol_l  <= cpol;
          pha_l  <= cpha;
          if (!cpha) mosi_q <= pick(tx_word, msb_first, len16);
        end
      end else begin
        cyc_q <= cyc_q + 1'b1;
        if (cyc_q == lead_at) begin
          sck_q <= ~pol_l;
          if (!pha_l) rx_sh <= samp(rx_sh, miso, msb_l);
          else begin
            mosi_q <= pick(tx_sh, msb_l, w16_l);
            tx_sh  <= adv(tx_sh, msb_l);
          end
        end
        if (cyc_q == div_l) begin
          sck_q <= pol_l;
          cyc_q <= '0;
          if (pha_l) rx_sh <= samp(rx_sh, miso, msb_l);
          else begin
            tx_sh  <= adv(tx_sh, msb_l);
            mosi_q <= pick(adv(tx_sh, msb_l), msb_l, w16_l);
          end
          if (last_bit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign rx_word = w16_l ? rx_sh
                 : (msb_l ? {{HALF{1'b0}}, rx_sh[HALF-1:0]}
                          : {{HALF{1'b0}}, rx_sh[WMAX-1:HALF]});

  assert_done_ends_word_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/spi_master_ctrl.sv
`timescale 1ns/1ps
module spi_master_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  op_mode_e          mode_q;
  logic              stop_q, cpol_q, cpha_q, msb_q, ien_q, len16_q, ovr_q, irq_q;
  logic [1:0]        thr_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  logic sel_mctl, sel_ctla, sel_ctlb, sel_stat, sel_data;
  logic buf_clr, data_push, data_pop;

  logic                tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0]    tx_cnt, rx_cnt;
  logic [WORD_MAX-1:0] tx_head, rx_head, sh_rx;
  logic                sh_busy, sh_done, sh_start, rx_level, idle;
  logic [2:0]          tx_cnt3, rx_cnt3;

  assign sel_mctl = (bus_addr == ADDR_W'(OFS_MCTL));
  assign sel_ctla = (bus_addr == ADDR_W'(OFS_CTLA));
  assign sel_ctlb = (bus_addr == ADDR_W'(OFS_CTLB));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));

  assign buf_clr   = bus_wr && sel_mctl && bus_wdata[0] && (bus_wdata[7:6] == MODE_CFG);
  assign data_push = bus_wr && sel_data;
  assign data_pop  = bus_rd && sel_data;
  assign sh_start  = (mode_q == MODE_ACT) && !stop_q && !sh_busy && !tx_empty;
  assign idle      = !sh_busy && tx_empty;

  spim_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clear(buf_clr),
    .push(data_push), .wdata(bus_wdata[WORD_MAX-1:0]),
    .pop(sh_start), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clear(buf_clr),
    .push(sh_done && !rx_full), .wdata(sh_rx),
    .pop(data_pop), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  spim_shifter #(.WMAX(WORD_MAX), .DW(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx_word(tx_head),
    .len16(len16_q), .msb_first(msb_q), .cpol(cpol_q), .cpha(cpha_q),
    .div(div_q), .miso(miso), .busy(sh_busy), .done(sh_done),
    .rx_word(sh_rx), .sck(sck), .mosi(mosi)
  );

  assign tx_cnt3  = 3'(tx_cnt);
  assign rx_cnt3  = 3'(rx_cnt);
  assign rx_level = ({1'b0, rx_cnt3} >= ({2'b00, thr_q} + 4'd1));

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_CFG;
      stop_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      msb_q   <= 1'b0;
      thr_q   <= 2'd0;
      ien_q   <= 1'b0;
      div_q   <= DIV_W'(1);
      len16_q <= 1'b0;
    end else if (bus_wr) begin
      if (sel_mctl) begin
        stop_q <= bus_wdata[1];
        if (bus_wdata[7:6] == MODE_CFG)      mode_q <= MODE_CFG;
        else if (bus_wdata[7:6] == MODE_ACT) mode_q <= MODE_ACT;
      end
      if (sel_ctla) begin
        thr_q <= bus_wdata[13:12];
        ien_q <= bus_wdata[9];
        if (mode_q == MODE_CFG) begin
          cpol_q <= bus_wdata[0];
          cpha_q <= bus_wdata[1];
          msb_q  <= bus_wdata[2];
        end
      end
      if (sel_ctlb && mode_q == MODE_CFG) begin
        div_q   <= (bus_wdata[15:8] == 8'd0) ? DIV_W'(1) : bus_wdata[8 +: DIV_W];
        len16_q <= (bus_wdata[4:0] == 5'd16);
      end
    end
  end

  // overrun flag and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (buf_clr)                 ovr_q <= 1'b0;
      else if (sh_done && rx_full) ovr_q <= 1'b1;
      irq_q <= ien_q && rx_level;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_mctl) rd_mux[7:0] = {mode_q, 4'b0000, stop_q, 1'b0};
    if (sel_ctla) rd_mux[15:0] = {2'b00, thr_q, 2'b00, ien_q, 6'b0, msb_q, cpha_q, cpol_q};
    if (sel_ctlb) rd_mux[15:0] = {div_q, 3'b000, len16_q ? 5'd16 : 5'd8};
    if (sel_stat) rd_mux[15:0] = {1'b0, rx_level, tx_cnt3, rx_cnt3, ovr_q, 4'b0, idle, 2'b00};
    if (sel_data) rd_mux[WORD_MAX-1:0] = rx_empty ? '0 : rx_head;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ACT) |=> ($stable(div_q) && $stable(len16_q) && $stable(cpol_q)
                              && $stable(cpha_q) && $stable(msb_q)));

  assert_start_only_active_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sh_busy) |-> $past(mode_q == MODE_ACT && !stop_q));

  assert_irq_follows_level_R10: assert property (@(posedge clk) disable iff (rst)
    (ien_q && rx_level) |=> irq);

  assert_overrun_sets_R11: assert property (@(posedge clk) disable iff (rst)
    (sh_done && rx_full && !buf_clr) |=> ovr_q);
endmodule

// File: tb/test_spi_master_ctrl.sv
`timescale 1ns/1ps
module test_spi_master_ctrl;
  localparam int A_MCTL = 'h00, A_CTLA = 'h04, A_CTLB = 'h08, A_STAT = 'h14, A_DATA = 'h18;

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic        msb;
    logic        l16;
    logic [7:0]  div;
    logic        inv;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 1'b0, 16'h07A5},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd2, 1'b1, 16'h003C},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 1'b0, 16'h001E},
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 1'b1, 16'h1234},
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd4, 1'b0, 16'hBEEF},
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 16'h0F01}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sck, mosi, miso;
  logic        inv_r = 1'b0;

  int n_tests = 0, n_fail = 0;
  logic        done_flag = 1'b0;

  always #2.5 clk = ~clk;
  assign miso = mosi ^ inv_r;

  spi_master_ctrl i_spi_master_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // serial monitor
  logic        mon_pol = 1'b0, mon_pha = 1'b0;
  logic [15:0] mon_sh = '0;
  int          mon_n = 0;
  time         last_lead = 0, mon_per = 0;

  always @(sck) begin
    if (sck !== mon_pol) begin
      if (last_lead != 0) mon_per = $time - last_lead;
      last_lead = $time;
      if (!mon_pha) begin mon_sh = {mon_sh[14:0], mosi}; mon_n++; end
    end else if (mon_pha) begin
      mon_sh = {mon_sh[14:0], mosi}; mon_n++;
    end
  end

  task automatic mon_clear();
    mon_sh = '0; mon_n = 0; last_lead = 0; mon_per = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = 8'(a); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int k;
    k = 0;
    brd(A_STAT, s);
    while (!s[2] && k < 20000) begin brd(A_STAT, s); k++; end
    if (!s[2]) check(req, 32'(s[2]), 32'd1);
  endtask

  function automatic logic [15:0] rev(input logic [15:0] d, input int w);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = d[w-1-i];
    return r;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 sck", 32'(sck), 32'd0);
    brd(A_MCTL, r); check("R1 mctl", r, 32'h40);
    brd(A_CTLA, r); check("R1 ctla", r, 32'h0);
    brd(A_CTLB, r); check("R1 ctlb", r, 32'h0108);
    brd(A_STAT, r); check("R1 R13 stat", r, 32'h0004);

    // R2 illegal mode code ignored
    bwr(A_MCTL, 32'hC0); brd(A_MCTL, r); check("R2 mode 11 ignored", r, 32'h40);

    // table of serial transfers: R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      automatic vec_t e = VEC[v];
      automatic int   w = e.l16 ? 16 : 8;
      automatic logic [15:0] m = e.l16 ? 16'hFFFF : 16'h00FF;
      automatic logic [15:0] exp_ser = e.msb ? (e.data & m) : rev(e.data, w);
      automatic logic [15:0] exp_rx  = (e.data ^ (e.inv ? 16'hFFFF : 16'h0)) & m;
      automatic int   per = ((e.div == 0) ? 2 : int'(e.div) + 1) * 5;
      bwr(A_MCTL, 32'h40);
      bwr(A_CTLA, {29'b0, e.msb, e.cpha, e.cpol});
      bwr(A_CTLB, {16'b0, e.div, 3'b000, e.l16 ? 5'd16 : 5'd8});
      if (e.div == 0) begin brd(A_CTLB, r); check("R4 div0 stored as 1", r, 32'h0110); end
      inv_r = e.inv; mon_pol = e.cpol; mon_pha = e.cpha;
      repeat (4) @(negedge clk);
      check("R6 idle sck level", 32'(sck), 32'(e.cpol));
      mon_clear();
      bwr(A_MCTL, 32'h80);
      bwr(A_DATA, {16'b0, e.data});
      wait_idle("R8 word finishes");
      check("R5 bit count", 32'(mon_n), 32'(w));
      check("R6 serial word", 32'(mon_sh & m), 32'(exp_ser));
      check("R4 sck period", 32'(mon_per), 32'(per));
      brd(A_DATA, r); check("R8 received word", r, 32'(exp_rx));
    end
    inv_r = 1'b0; mon_pol = 1'b0; mon_pha = 1'b0;

    // R7 transmit FIFO depth, R8 no shifting in config mode
    bwr(A_MCTL, 32'h41);
    bwr(A_CTLA, 32'h4);
    bwr(A_CTLB, 32'h0108);
    for (int i = 1; i <= 5; i++) bwr(A_DATA, 32'(i * 'h11));
    repeat (10) @(negedge clk);
    brd(A_STAT, r); check("R7 tx full at 4", r, 32'h2000);
    bwr(A_MCTL, 32'h80);
    wait_idle("R8 drain");
    brd(A_STAT, r); check("R9 R10 R13 rx four", r, 32'h4404);
    for (int i = 1; i <= 4; i++) begin
      brd(A_DATA, r); check("R9 pop order", r, 32'(i * 'h11));
    end
    brd(A_DATA, r); check("R9 empty read", r, 32'h0);

    // R3 gating in active mode, R10 threshold
    bwr(A_MCTL, 32'h41);
    bwr(A_CTLA, 32'h4);
    bwr(A_CTLB, 32'h0108);
    bwr(A_MCTL, 32'h80);
    bwr(A_CTLA, 32'h2207);
    brd(A_CTLA, r); check("R3 ctla in active", r, 32'h2204);
    bwr(A_CTLB, 32'h0510);
    brd(A_CTLB, r); check("R3 ctlb in active", r, 32'h0108);
    bwr(A_DATA, 32'h10); bwr(A_DATA, 32'h20);
    wait_idle("R10 two");
    brd(A_STAT, r); check("R10 below threshold", r, 32'h0204);
    check("R10 irq low", 32'(irq), 32'd0);
    bwr(A_DATA, 32'h30);
    wait_idle("R10 three");
    brd(A_STAT, r); check("R10 threshold reached", r, 32'h4304);
    check("R10 irq high", 32'(irq), 32'd1);
    brd(A_DATA, r); check("R9 first word", r, 32'h10);
    repeat (2) @(negedge clk);
    check("R10 irq drops", 32'(irq), 32'd0);

    // R11 overrun
    bwr(A_DATA, 32'h40); bwr(A_DATA, 32'h50); bwr(A_DATA, 32'h60);
    wait_idle("R11 drain");
    brd(A_STAT, r); check("R11 overrun flag", r, 32'h4484);
    brd(A_DATA, r); check("R11 oldest kept", r, 32'h20);

    // R12 buffer clear
    bwr(A_MCTL, 32'h41);
    brd(A_MCTL, r); check("R12 clear self-clears", r, 32'h40);
    brd(A_STAT, r); check("R11 R12 cleared", r, 32'h0004);
    bwr(A_DATA, 32'h71); bwr(A_DATA, 32'h72);
    brd(A_STAT, r); check("R13 not idle with tx", r, 32'h1000);
    bwr(A_MCTL, 32'h41);
    brd(A_STAT, r); check("R12 tx emptied", r, 32'h0004);

    // R2 R8 stop bit holds words
    bwr(A_MCTL, 32'h82);
    bwr(A_DATA, 32'h5A);
    repeat (40) @(negedge clk);
    brd(A_STAT, r); check("R8 stop holds", r, 32'h0800);
    bwr(A_MCTL, 32'h80);
    wait_idle("R8 resume");
    brd(A_STAT, r); check("R8 after resume", r, 32'h0104);

    // R14 leaving active mode mid-word
    bwr(A_MCTL, 32'h41);
    bwr(A_CTLB, 32'h0910);
    bwr(A_MCTL, 32'h80);
    bwr(A_DATA, 32'hA001); bwr(A_DATA, 32'hA002); bwr(A_DATA, 32'hA003);
    repeat (10) @(negedge clk);
    bwr(A_MCTL, 32'h40);
    repeat (400) @(negedge clk);
    brd(A_STAT, r); check("R14 one word then hold", r, 32'h1100);
    brd(A_DATA, r); check("R14 finished word", r, 32'hA001);

    done_flag = 1'b1;
    finish_run();
  end
endmodule